// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical address by walking a two-level translation table in memory. Each walk reads a directory entry and then a leaf table entry. It checks the entries for presence and access rights, and it marks them as accessed, and as dirty on a write. Any entry whose flags change is written back before the result is returned. A successful walk hands the physical address and the updated leaf entry to the translation cache. A failed walk reports a fault with its cause and the details of the access.

The walker takes one request at a time. The request carries the virtual address, the access kind (write or read), the privilege (user or supervisor) and the directory base to use. All table traffic goes through one 32-bit memory port with a valid/ready request channel and a read-data strobe. Pages are 4 KB. The top 10 address bits index the directory and the next 10 bits index the leaf table.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read from {base[31:12], va[31:22], 2'b00}, and the leaf entry is read from {directory entry[31:12], va[21:12], 2'b00}.
- R2: A successful walk raises done_valid with done_paddr = {leaf entry[31:12], va[11:0]} and done_pte = the leaf entry as written back.
- R3: An entry with bit 0 (present) clear at either level ends the walk with fault cause 0 (absent). No further entry is read, and the other bits of that entry are ignored.
- R4: A present directory entry with bit 7 (page size) set ends the walk with fault cause 2 (unsupported entry).
- R5: A write through an entry with bit 1 (writable) clear, or a user access through an entry with bit 2 (user) clear, at either level, ends the walk with fault cause 1 (protection).
- R6: A fault reports the request's virtual address, its write flag and its user flag.
- R7: Every entry that passes its checks gets bit 5 (accessed) set. The leaf also gets bit 6 (dirty) set on a write. An entry is written back only when its value changes. A faulting entry is never written.
- R8: All write-backs of a walk finish before its single result. Exactly one of done_valid or fault_valid pulses for one cycle per request, and req_ready stays low from acceptance until that pulse.
- R9: After reset the walker is idle: req_ready is high and mem_valid, done_valid and fault_valid are low.
- R10: mem_valid, mem_addr and mem_we stay unchanged from when a memory request is raised until mem_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| dir_base | input | 32 | Physical base of the directory (bits 31:12 used) |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done_valid | output | 1 | Translation result pulse |
| done_paddr | output | 32 | Physical address |
| done_pte | output | 32 | Updated leaf entry |
| fault_valid | output | 1 | Fault pulse |
| fault_vaddr | output | 32 | Faulting virtual address |
| fault_cause | output | 2 | 0 absent, 1 protection, 2 unsupported |
| fault_write | output | 1 | Faulting access was a write |
| fault_user | output | 1 | Faulting access was user mode |

## Verification
The properties assume a well-behaved memory. It returns exactly one read-data strobe for each accepted read and never raises one otherwise. It also assumes no second request is offered before the previous walk has produced its result. The bench memory model follows this rule: it accepts one request at a time, holds ready back for a few cycles and answers reads after a varying delay. The driver issues a new walk only after the scoreboard has consumed the previous outcome.

// File: rtl/pt_walker_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 4-byte entries and two equal-width index fields.
package pt_walker_pkg;
    localparam int PW_ADDR_W = 32;
    localparam int PW_IDX_W  = 10;
    localparam int PW_OFF_W  = 12;

    // Entry flag positions
    localparam int FLG_PRESENT = 0;
    localparam int FLG_WRITE   = 1;
    localparam int FLG_USER    = 2;
    localparam int FLG_ACCESS  = 5;
    localparam int FLG_DIRTY   = 6;
    localparam int FLG_BIGPAGE = 7;

    typedef enum logic [1:0] {
        CAUSE_ABSENT  = 2'd0,
        CAUSE_PROT    = 2'd1,
        CAUSE_BADSIZE = 2'd2
    } fault_cause_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_DIR_WB,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_TBL_WB,
        ST_DONE,
        ST_FAULT
    } walk_state_e;
endpackage

// File: rtl/pte_check.sv
// Checks one fetched entry against the access and computes its updated value.
// IS_LEAF selects the leaf-level variant: it sets the dirty flag on writes and
// does not treat the size flag as a fault.
// Assumes the entry is valid in the cycle it is presented.
module pte_check
    import pt_walker_pkg::*;
#(
    parameter int DATA_W  = PW_ADDR_W,
    parameter bit IS_LEAF = 1'b0
) (
    input  logic [DATA_W-1:0] entry,
    input  logic              acc_write,
    input  logic              acc_user,
    output logic              pass,
    output fault_cause_e      cause,
    output logic [DATA_W-1:0] updated,
    output logic              changed
);
    logic present;
    logic size_bad;
    logic denied;
    logic [DATA_W-1:0] set_mask;

    // Classify the entry against the requested access
    always_comb begin
        present  = entry[FLG_PRESENT];
        denied   = (acc_write && !entry[FLG_WRITE]) || (acc_user && !entry[FLG_USER]);
        size_bad = 1'b0;
        if (!IS_LEAF) begin
            size_bad = entry[FLG_BIGPAGE];
        end
        pass = present && !size_bad && !denied;
        if (!present) begin
            cause = CAUSE_ABSENT;
        end else if (size_bad) begin
            cause = CAUSE_BADSIZE;
        end else begin
            cause = CAUSE_PROT;
        end
    end

    // Build the flag update and detect whether it alters the entry
    always_comb begin
        set_mask = '0;
        set_mask[FLG_ACCESS] = 1'b1;
        if (IS_LEAF) begin
            set_mask[FLG_DIRTY] = acc_write;
        end
        updated = entry | set_mask;
        changed = (updated != entry);
    end
endmodule

// File: rtl/pt_addr_gen.sv
// Forms the directory entry address, the leaf entry address and the final
// physical address from the latched context.
// Assumes OFF_W = IDX_W + log2(entry bytes) and ADDR_W = 2*IDX_W + OFF_W.
module pt_addr_gen
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = PW_ADDR_W,
    parameter int IDX_W  = PW_IDX_W,
    parameter int OFF_W  = PW_OFF_W
) (
    input  logic [ADDR_W-1:0] vaddr,
    input  logic [ADDR_W-OFF_W-1:0] root_frame,
    input  logic [ADDR_W-OFF_W-1:0] table_frame,
    input  logic [ADDR_W-OFF_W-1:0] page_frame,
    output logic [ADDR_W-1:0] dir_addr,
    output logic [ADDR_W-1:0] tbl_addr,
    output logic [ADDR_W-1:0] phys_addr
);
    localparam int BYTE_W = OFF_W - IDX_W;
    localparam int HI_LSB = ADDR_W - IDX_W;
    localparam int LO_LSB = OFF_W;

    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;

    // Split the virtual address and concatenate the three addresses
    always_comb begin
        hi_idx    = vaddr[HI_LSB +: IDX_W];
        lo_idx    = vaddr[LO_LSB +: IDX_W];
        dir_addr  = {root_frame,  hi_idx, {BYTE_W{1'b0}}};
        tbl_addr  = {table_frame, lo_idx, {BYTE_W{1'b0}}};
        phys_addr = {page_frame,  vaddr[OFF_W-1:0]};
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker. It accepts one request at a time, reads the
// directory entry and then the leaf entry over one memory port, checks both
// and writes back changed flags. It ends with a one-cycle result or fault pulse.
// Assumes the memory answers each accepted read with exactly one rvalid.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = PW_ADDR_W,
    parameter int IDX_W  = PW_IDX_W,
    parameter int OFF_W  = PW_OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic [ADDR_W-1:0] dir_base,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [ADDR_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_paddr,
    output logic [ADDR_W-1:0] done_pte,
    output logic              fault_valid,
    output logic [ADDR_W-1:0] fault_vaddr,
    output logic [1:0]        fault_cause,
    output logic              fault_write,
    output logic              fault_user
);
    localparam int FRAME_W = ADDR_W - OFF_W;

    walk_state_e       state_q;
    logic [ADDR_W-1:0] va_q;
    logic              wr_q;
    logic              us_q;
    logic [FRAME_W-1:0] root_q;
    logic [ADDR_W-1:0] dir_q;
    logic [ADDR_W-1:0] leaf_q;
    fault_cause_e      cause_q;

    logic [ADDR_W-1:0] dir_addr;
    logic [ADDR_W-1:0] tbl_addr;
    logic [ADDR_W-1:0] phys_addr;

    logic              lvl_pass   [2];
    fault_cause_e      lvl_cause  [2];
    logic [ADDR_W-1:0] lvl_update [2];
    logic              lvl_change [2];

    pt_addr_gen #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .OFF_W  (OFF_W)
    ) i_addr (
        .vaddr       (va_q),
        .root_frame  (root_q),
        .table_frame (dir_q[ADDR_W-1:OFF_W]),
        .page_frame  (leaf_q[ADDR_W-1:OFF_W]),
        .dir_addr    (dir_addr),
        .tbl_addr    (tbl_addr),
        .phys_addr   (phys_addr)
    );

    // One checker per level; level 0 is the directory, level 1 the leaf
    for (genvar lv = 0; lv < 2; lv++) begin : g_level
        pte_check #(
            .DATA_W  (ADDR_W),
            .IS_LEAF (lv == 1)
        ) i_check (
            .entry     (mem_rdata),
            .acc_write (wr_q),
            .acc_user  (us_q),
            .pass      (lvl_pass[lv]),
            .cause     (lvl_cause[lv]),
            .updated   (lvl_update[lv]),
            .changed   (lvl_change[lv])
        );
    end

    // Walk sequencing and capture of request context and fetched entries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            va_q    <= '0;
            wr_q    <= 1'b0;
            us_q    <= 1'b0;
            root_q  <= '0;
            dir_q   <= '0;
            leaf_q  <= '0;
            cause_q <= CAUSE_ABSENT;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        wr_q    <= req_write;
                        us_q    <= req_user;
                        root_q  <= dir_base[ADDR_W-1:OFF_W];
                        state_q <= ST_DIR_REQ;
                    end
                end
                ST_DIR_REQ: begin
                    if (mem_ready) state_q <= ST_DIR_WAIT;
                end
                ST_DIR_WAIT: begin
                    if (mem_rvalid) begin
                        dir_q <= lvl_update[0];
                        if (!lvl_pass[0]) begin
                            cause_q <= lvl_cause[0];
                            state_q <= ST_FAULT;
                        end else if (lvl_change[0]) begin
                            state_q <= ST_DIR_WB;
                        end else begin
                            state_q <= ST_TBL_REQ;
                        end
                    end
                end
                ST_DIR_WB: begin
                    if (mem_ready) state_q <= ST_TBL_REQ;
                end
                ST_TBL_REQ: begin
                    if (mem_ready) state_q <= ST_TBL_WAIT;
                end
                ST_TBL_WAIT: begin
                    if (mem_rvalid) begin
                        leaf_q <= lvl_update[1];
                        if (!lvl_pass[1]) begin
                            cause_q <= lvl_cause[1];
                            state_q <= ST_FAULT;
                        end else if (lvl_change[1]) begin
                            state_q <= ST_TBL_WB;
                        end else begin
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_TBL_WB: begin
                    if (mem_ready) state_q <= ST_DONE;
                end
                ST_DONE:  state_q <= ST_IDLE;
                ST_FAULT: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory request for the current walk step
    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = dir_addr;
        mem_wdata = dir_q;
        case (state_q)
            ST_DIR_REQ: begin
                mem_valid = 1'b1;
            end
            ST_DIR_WB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
            end
            ST_TBL_REQ: begin
                mem_valid = 1'b1;
                mem_addr  = tbl_addr;
            end
            ST_TBL_WB: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_addr;
                mem_wdata = leaf_q;
            end
            default: ;
        endcase
    end

    // Present the outcome of the walk
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        done_valid  = (state_q == ST_DONE);
        done_paddr  = phys_addr;
        done_pte    = leaf_q;
        fault_valid = (state_q == ST_FAULT);
        fault_vaddr = va_q;
        fault_cause = cause_q;
        fault_write = wr_q;
        fault_user  = us_q;
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Property checker for pt_walker, attached through bind.
// Assumes a memory that answers each accepted read exactly once.
module pt_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_valid,
    input logic              mem_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] mem_wdata,
    input logic              done_valid,
    input logic [ADDR_W-1:0] done_pte,
    input logic              fault_valid,
    input logic [1:0]        fault_cause
);
    // R8
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_valid && fault_valid));

    // R8
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    outcome_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid || fault_valid) |=> !(done_valid || fault_valid));

    // R10
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

    // R7
    wb_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |-> mem_wdata[5]);

    // R2
    leaf_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_pte[0] && done_pte[5]));

    // R3
    cause_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (fault_cause != 2'd3));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) i_pt_walker_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .done_valid  (done_valid),
    .done_pte    (done_pte),
    .fault_valid (fault_valid),
    .fault_cause (fault_cause)
);

// File: tb/test_pt_walker.sv
// Scoreboard bench for pt_walker: the driver predicts each walk from the
// requirements and queues it, the monitor compares every outcome pulse.
module test_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] dir_base = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic [31:0] done_pte;
    logic        fault_valid;
    logic [31:0] fault_vaddr;
    logic [1:0]  fault_cause;
    logic        fault_write;
    logic        fault_user;

    always #2 clk = ~clk;

    pt_walker i_pt_walker (.*);

    typedef struct {
        bit          is_fault;
        logic [1:0]  cause;
        string       tag;
        logic [31:0] va;
        bit          wr;
        bit          us;
        logic [31:0] paddr;
        logic [31:0] pte;
        int          nwr;
        int          didx;
        logic [31:0] dword;
        bit          has_leaf;
        int          tidx;
        logic [31:0] tword;
    } exp_t;

    exp_t        sb_q[$];
    logic [31:0] mem [0:4095];
    int total = 0;
    int bad = 0;
    int popped = 0;
    int wr_count = 0;
    int latency = 0;
    bit rd_pend = 0;
    int rd_wait = 0;
    int rd_idx = 0;
    int hold_cnt = 0;
    logic [31:0] hold_addr = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Memory model: delayed acceptance, delayed read data
    initial begin
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (rd_pend) begin
                if (rd_wait == 0) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = mem[rd_idx];
                    rd_pend    = 0;
                end else begin
                    rd_wait--;
                end
            end
            if (mem_ready) begin
                mem_ready = 1'b0;
                hold_cnt  = 0;
            end else if (mem_valid && !rd_pend) begin
                if (hold_cnt == 0) hold_addr = mem_addr;
                if (hold_cnt < latency) begin
                    hold_cnt++;
                end else begin
                    // R10: request held unchanged while waiting for ready
                    chk(mem_addr == hold_addr, "R10", "held address", mem_addr, hold_addr);
                    mem_ready = 1'b1;
                    if (mem_we) begin
                        mem[mem_addr[13:2]] = mem_wdata;
                        wr_count++;
                    end else begin
                        rd_pend = 1;
                        rd_wait = latency;
                        rd_idx  = int'(mem_addr[13:2]);
                    end
                end
            end
        end
    end

    // Monitor: compare every outcome against the queued prediction
    initial begin
        forever begin
            @(negedge clk);
            if (done_valid || fault_valid) begin
                exp_t e;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected outcome", 32'(done_valid), 32'd0);
                end else begin
                    e = sb_q.pop_front();
                    chk(fault_valid == e.is_fault && done_valid != e.is_fault, e.tag,
                        "outcome kind", 32'(fault_valid), 32'(e.is_fault));
                    if (e.is_fault) begin
                        chk(fault_cause == e.cause, e.tag, "fault cause", 32'(fault_cause), 32'(e.cause));
                        chk(fault_vaddr == e.va && fault_write == e.wr && fault_user == e.us, "R6",
                            "fault details", fault_vaddr, e.va);
                    end else begin
                        chk(done_paddr == e.paddr, "R1", "physical address", done_paddr, e.paddr);
                        chk(done_pte == e.pte, "R2", "returned entry", done_pte, e.pte);
                    end
                    chk(wr_count == e.nwr, "R8", "write-backs before result", wr_count, e.nwr);
                    chk(mem[e.didx] == e.dword, "R7", "directory entry in memory", mem[e.didx], e.dword);
                    if (e.has_leaf)
                        chk(mem[e.tidx] == e.tword, "R7", "leaf entry in memory", mem[e.tidx], e.tword);
                    chk(!req_ready, "R8", "busy until result", 32'(req_ready), 32'd0);
                end
                popped++;
            end
        end
    end

    // Predict one walk from the current memory image
    function automatic exp_t predict(input logic [31:0] va, input bit wr, input bit us,
                                     input logic [31:0] base);
        exp_t e;
        logic [31:0] d;
        logic [31:0] t;
        e = '{default: '0};
        e.tag = "R2";
        e.va = va; e.wr = wr; e.us = us;
        e.didx = int'(((base & 32'hFFFF_F000) + {20'd0, va[31:22], 2'b00}) >> 2) & 4095;
        d = mem[e.didx];
        e.dword = d;
        if (!d[0]) begin
            e.is_fault = 1; e.cause = 2'd0; e.tag = "R3"; return e;
        end
        if (d[7]) begin
            e.is_fault = 1; e.cause = 2'd2; e.tag = "R4"; return e;
        end
        if ((wr && !d[1]) || (us && !d[2])) begin
            e.is_fault = 1; e.cause = 2'd1; e.tag = "R5"; return e;
        end
        e.dword = d | 32'h20;
        if (e.dword != d) e.nwr++;
        e.has_leaf = 1;
        e.tidx = int'(((d & 32'hFFFF_F000) + {20'd0, va[21:12], 2'b00}) >> 2) & 4095;
        t = mem[e.tidx];
        e.tword = t;
        if (!t[0]) begin
            e.is_fault = 1; e.cause = 2'd0; e.tag = "R3"; return e;
        end
        if ((wr && !t[1]) || (us && !t[2])) begin
            e.is_fault = 1; e.cause = 2'd1; e.tag = "R5"; return e;
        end
        e.tword = t | 32'h20 | (wr ? 32'h40 : 32'h0);
        if (e.tword != t) e.nwr++;
        e.pte = e.tword;
        e.paddr = {t[31:12], va[11:0]};
        return e;
    endfunction

    // Driver: queue the prediction, issue the request, wait for its outcome
    task automatic walk(input logic [31:0] va, input bit wr, input bit us,
                        input logic [31:0] base, input int lat);
        int target;
        sb_q.push_back(predict(va, wr, us, base));
        target = popped + 1;
        @(negedge clk);
        latency   = lat;
        wr_count  = 0;
        dir_base  = base;
        req_vaddr = va;
        req_write = wr;
        req_user  = us;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (popped < target) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        // directory at 0x0000
        mem[0] = 32'h0000_1007;
        mem[2] = 32'h0000_2003;
        mem[3] = 32'h0040_0087;
        mem[4] = 32'h0000_1005;
        mem[5] = 32'h0000_0086;
        // leaf table at 0x1000
        mem[1024 + 5] = 32'h00AB_C007;
        mem[1024 + 6] = 32'h00DE_F005;
        mem[1024 + 8] = 32'h0011_1003;
        // leaf table at 0x2000
        mem[2048 + 0] = 32'h0033_3027;
        mem[2048 + 1] = 32'h0022_2007;
        // second directory at 0x3000
        mem[3072] = 32'h0000_2007;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: idle after reset
        chk(req_ready && !mem_valid && !done_valid && !fault_valid, "R9", "reset state",
            {mem_valid, done_valid, fault_valid, req_ready}, 32'h1);

        walk(32'h0000_5123, 0, 1, 32'h0, 0);   // R1 R7: both accessed flags set
        walk(32'h0000_5123, 0, 1, 32'h0, 2);   // R7: nothing changes, no write
        walk(32'h0000_5123, 1, 1, 32'h0, 1);   // R7: dirty set in leaf
        walk(32'h0000_5123, 1, 1, 32'h0, 0);   // R7: already dirty
        walk(32'h0000_6456, 1, 1, 32'h0, 1);   // R5: read-only leaf
        walk(32'h0000_6456, 0, 1, 32'h0, 2);
        walk(32'h0000_7000, 0, 0, 32'h0, 0);   // R3: absent leaf
        walk(32'h0000_8000, 0, 1, 32'h0, 1);   // R5: supervisor leaf
        walk(32'h0000_8010, 1, 0, 32'h0, 0);
        walk(32'h0040_0000, 0, 1, 32'h0, 2);   // R3: absent directory entry
        walk(32'h0080_1ABC, 0, 1, 32'h0, 0);   // R5: supervisor directory entry
        walk(32'h0080_1ABC, 0, 0, 32'h0, 1);
        walk(32'h00C0_0000, 0, 0, 32'h0, 0);   // R4: page-size flag
        walk(32'h0100_5000, 1, 1, 32'h0, 2);   // R5: read-only directory entry
        walk(32'h0100_5000, 0, 1, 32'h0, 0);
        walk(32'h0140_0000, 1, 1, 32'h0, 1);   // R3: absent wins over size flag
        walk(32'h0000_0777, 1, 1, 32'h3000, 2); // R1: other directory base

        repeat (4) @(negedge clk);
        chk(sb_q.size() == 0, "R8", "all outcomes seen", sb_q.size(), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule